// File: doc/BRIEF.md
# Packetized memory command receiver

This block sits at the command input of a DRAM device that has no chip-select pin. The controller shares a narrow command bus among many devices and sends each command as a 40-bit packet. The packet arrives as four 10-bit words on four consecutive cycles. A start flag marks the first word of each packet. The double-data-rate capture of the words is modelled as one word per clock cycle. The receiver assembles the four words and splits out the destination ID, the 6-bit command code, the bank, the row and the column. It then decides whether the packet is meant for this device.

The device learns its 8-bit ID while reset is held. A packet can name one device or any aligned power-of-two group of devices, up to all of them. For each packet addressed to this device, the block raises one command-valid pulse. Alongside the pulse it presents the fields and the decoded read/write option bits. Maintenance commands are passed on as non-data with the code undecoded. A start flag that arrives in the middle of a packet abandons the partial packet and raises a one-cycle error pulse.

Top module: `pkt_cmd_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, cmd_valid and proto_err are 0. No packet is in progress after reset.
- R2: A packet is a word with bus_flag=1 followed by three words with bus_flag=0. cmd_valid is high for exactly the one cycle after the cycle in which the fourth word is presented.
- R3: Field positions are as follows. Word 0 [9:1] is the 9-bit destination ID and word 0 [0] is code bit 5. Word 1 [9:5] is code bits 4:0, word 1 [4:2] is the bank and word 1 [1:0] is row bits 10:9. Word 2 [9:1] is row bits 8:0. Word 3 [6:0] is the column. These fields appear on the outputs while cmd_valid is high.
- R4: When ID bit 8 is 0, the packet matches only if ID bits 7:0 equal the device's own ID.
- R5: When ID bit 8 is 1, the match ignores ID bits 0 up to and including the lowest 0 bit among bits 7:0. All higher bits must be equal.
- R6: ID 9'h1FF matches every device.
- R7: A packet that does not match produces no cmd_valid.
- R8: When code bit 5 is 0, cmd_is_data=1 and the option outputs follow the code. Bit 4 drives cmd_activate, bit 3 drives cmd_burst8 (8-word burst), bit 2 drives cmd_write, bit 1 drives cmd_close and bit 0 drives cmd_dclk_sel.
- R9: When code bit 5 is 1, cmd_is_data=0, all five option outputs are 0, and cmd_code carries the raw 6-bit code.
- R10: If bus_flag=1 arrives while a packet is partly received, proto_err is 1 in that same cycle. The partial packet is dropped, and that word becomes word 0 of a new packet.
- R11: Words with bus_flag=0 that arrive while no packet is in progress are ignored. They cause no cmd_valid and no proto_err.
- R12: The own ID is dev_id_in as sampled while reset is high. Later changes on dev_id_in do not alter matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one command word per cycle |
| rst | input | 1 | Synchronous active-high reset; own ID is sampled while high |
| dev_id_in | input | 8 | ID assigned to this device at reset |
| bus_flag | input | 1 | Start-of-packet flag |
| bus_word | input | 10 | Command word |
| cmd_valid | output | 1 | One-cycle pulse for an accepted packet |
| cmd_is_data | output | 1 | 1 for a read/write access, 0 for maintenance |
| cmd_activate | output | 1 | Open the row before the access |
| cmd_burst8 | output | 1 | 8-word burst (else 4-word) |
| cmd_write | output | 1 | Write (else read) |
| cmd_close | output | 1 | Close the row after the access |
| cmd_dclk_sel | output | 1 | Data clock pair select |
| cmd_code | output | 6 | Raw command code |
| cmd_bank | output | 3 | Bank address |
| cmd_row | output | 11 | Row address |
| cmd_col | output | 7 | Column address |
| proto_err | output | 1 | Start flag seen in the middle of a packet |

## Verification
The ID match is tried with several kinds of destination ID:
- exact unicast hits and misses that differ in a single bit, which separates exact matching from masked matching;
- group IDs whose lowest zero sits at different bit positions, which shows whether the ignored span stops at the right bit;
- the broadcast ID.

Framing is tried with several streams:
- back-to-back packets;
- a packet cut short by a new flag;
- flag-free noise on an idle bus.

These streams separate correct word counting from an off-by-one or a missed restart. Data and maintenance codes with distinct bit patterns check each option output and the field positions.

// File: rtl/pkt_cmd_pkg.sv
package pkt_cmd_pkg;
    localparam int WORD_W    = 10;
    localparam int PKT_WORDS = 4;
    localparam int PKT_BITS  = WORD_W * PKT_WORDS;
    localparam int ID_W      = 8;
    localparam int TXID_W    = ID_W + 1;
    localparam int CODE_W    = 6;
    localparam int BANK_W    = 3;
    localparam int ROW_W     = 11;
    localparam int COL_W     = 7;

    typedef struct packed {
        logic [TXID_W-1:0] dest;
        logic [CODE_W-1:0] code;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } pkt_fields_t;

    typedef struct packed {
        logic is_data;
        logic activate;
        logic burst8;
        logic write;
        logic close;
        logic dclk_sel;
    } opt_t;

    // Split a flat packet (word 0 in the top bits) into its fields.
    function automatic pkt_fields_t unpack_pkt(input logic [PKT_BITS-1:0] b);
        pkt_fields_t f;
        f.dest = b[39:31];
        f.code = b[30:25];
        f.bank = b[24:22];
        f.row  = b[21:11];
        f.col  = b[6:0];
        return f;
    endfunction
endpackage

// File: rtl/pkt_framer.sv
module pkt_framer
    import pkt_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_flag,
    input  logic [WORD_W-1:0]   bus_word,
    output logic                pkt_done,
    output logic [PKT_BITS-1:0] pkt_bits,
    output logic                restart
);
    localparam int IDX_W = $clog2(PKT_WORDS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_WORDS - 1);

    logic             busy;
    logic [IDX_W-1:0] idx;
    logic [WORD_W-1:0] held [PKT_WORDS-1];
    logic [PKT_BITS-1:0] flat;

    assign restart = bus_flag && busy;

    always_comb begin
        flat = '0;
        for (int k = 0; k < PKT_WORDS - 1; k++) begin
            flat[PKT_BITS-1-k*WORD_W -: WORD_W] = held[k];
        end
        flat[WORD_W-1:0] = bus_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            idx      <= '0;
            pkt_done <= 1'b0;
            pkt_bits <= '0;
            for (int k = 0; k < PKT_WORDS - 1; k++) held[k] <= '0;
        end else begin
            pkt_done <= 1'b0;
            if (bus_flag) begin
                held[0] <= bus_word;
                idx     <= IDX_W'(1);
                busy    <= 1'b1;
            end else if (busy) begin
                if (idx == LAST) begin
                    pkt_bits <= flat;
                    pkt_done <= 1'b1;
                    busy     <= 1'b0;
                    idx      <= '0;
                end else begin
                    held[idx] <= bus_word;
                    idx       <= idx + IDX_W'(1);
                end
            end
        end
    end

    // R2: a completed packet always follows the last word of an open packet
    p_done_after_last_r2: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> $past(busy && idx == LAST && !bus_flag));
    // R2: completion lasts one cycle
    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        pkt_done |=> !pkt_done);
    // R10: a restart leaves the framer expecting word 1
    p_restart_word1_r10: assert property (@(posedge clk) disable iff (rst)
        restart |=> (busy && idx == IDX_W'(1)));
endmodule

// File: rtl/pkt_id_match.sv
module pkt_id_match
    import pkt_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   dev_id_in,
    input  logic [TXID_W-1:0] tx_id,
    output logic              hit
);
    logic [ID_W-1:0] my_id;
    logic [ID_W-1:0] low;
    logic [ID_W-1:0] ign;

    always_ff @(posedge clk) begin
        if (rst) my_id <= dev_id_in;
    end

    assign low = tx_id[ID_W-1:0];
    // Bits from 0 up to and including the lowest zero of low.
    assign ign = low ^ (low + ID_W'(1));

    always_comb begin
        if (tx_id[ID_W]) hit = ((low ^ my_id) & ~ign) == '0;
        else             hit = (low == my_id);
    end

    // R6: broadcast always matches
    p_broadcast_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_id == {TXID_W{1'b1}}) |-> hit);
    // R4: unicast hits only on exact equality
    p_unicast_exact_r4: assert property (@(posedge clk) disable iff (rst)
        (!tx_id[ID_W] && hit) |-> (tx_id[ID_W-1:0] == my_id));
endmodule

// File: rtl/pkt_cmd_decode.sv
module pkt_cmd_decode
    import pkt_cmd_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output opt_t              opt
);
    always_comb begin
        opt = '0;
        if (!code[5]) begin
            opt.is_data  = 1'b1;
            opt.activate = code[4];
            opt.burst8   = code[3];
            opt.write    = code[2];
            opt.close    = code[1];
            opt.dclk_sel = code[0];
        end
    end
endmodule

// File: rtl/pkt_cmd_rx.sv
module pkt_cmd_rx
    import pkt_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   dev_id_in,
    input  logic              bus_flag,
    input  logic [WORD_W-1:0] bus_word,
    output logic              cmd_valid,
    output logic              cmd_is_data,
    output logic              cmd_activate,
    output logic              cmd_burst8,
    output logic              cmd_write,
    output logic              cmd_close,
    output logic              cmd_dclk_sel,
    output logic [CODE_W-1:0] cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              proto_err
);
    logic                pkt_done;
    logic [PKT_BITS-1:0] pkt_bits;
    logic                hit;
    pkt_fields_t         fld;
    opt_t                opt;

    pkt_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .bus_flag (bus_flag),
        .bus_word (bus_word),
        .pkt_done (pkt_done),
        .pkt_bits (pkt_bits),
        .restart  (proto_err)
    );

    assign fld = unpack_pkt(pkt_bits);

    pkt_id_match u_match (
        .clk       (clk),
        .rst       (rst),
        .dev_id_in (dev_id_in),
        .tx_id     (fld.dest),
        .hit       (hit)
    );

    pkt_cmd_decode u_dec (
        .code (fld.code),
        .opt  (opt)
    );

    assign cmd_valid    = pkt_done && hit;
    assign cmd_is_data  = opt.is_data;
    assign cmd_activate = opt.activate;
    assign cmd_burst8   = opt.burst8;
    assign cmd_write    = opt.write;
    assign cmd_close    = opt.close;
    assign cmd_dclk_sel = opt.dclk_sel;
    assign cmd_code     = fld.code;
    assign cmd_bank     = fld.bank;
    assign cmd_row      = fld.row;
    assign cmd_col      = fld.col;

    // R2: no two valid pulses in a row
    p_valid_single_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);
    // R9: a maintenance command carries no option bits
    p_maint_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code[5]) |-> !(cmd_write || cmd_burst8 || cmd_activate));
endmodule

// File: tb/pkt_cmd_rx_tb.sv
module pkt_cmd_rx_tb;
    logic        clk = 0;
    logic        rst;
    logic [7:0]  dev_id_in;
    logic        bus_flag;
    logic [9:0]  bus_word;
    logic        cmd_valid, cmd_is_data, cmd_activate, cmd_burst8;
    logic        cmd_write, cmd_close, cmd_dclk_sel, proto_err;
    logic [5:0]  cmd_code;
    logic [2:0]  cmd_bank;
    logic [10:0] cmd_row;
    logic [6:0]  cmd_col;

    int total = 0;
    int bad   = 0;

    localparam logic [7:0] OWN_ID = 8'hA5;

    always #5 clk = ~clk;

    pkt_cmd_rx u_dut (
        .clk(clk), .rst(rst), .dev_id_in(dev_id_in),
        .bus_flag(bus_flag), .bus_word(bus_word),
        .cmd_valid(cmd_valid), .cmd_is_data(cmd_is_data),
        .cmd_activate(cmd_activate), .cmd_burst8(cmd_burst8),
        .cmd_write(cmd_write), .cmd_close(cmd_close),
        .cmd_dclk_sel(cmd_dclk_sel), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .proto_err(proto_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit ref_match(input logic [8:0] tx, input logic [7:0] me);
        logic [7:0] care = 8'hFF;
        if (!tx[8]) return tx[7:0] == me;
        for (int i = 0; i < 8; i++) begin
            care[i] = 1'b0;
            if (!tx[i]) break;
        end
        return ((tx[7:0] ^ me) & care) == 8'h00;
    endfunction

    task automatic drive(input logic f, input logic [9:0] w);
        @(negedge clk);
        bus_flag = f;
        bus_word = w;
    endtask

    task automatic send_words(input logic [8:0] id, input logic [5:0] code,
                              input logic [2:0] bank, input logic [10:0] row,
                              input logic [6:0] col);
        drive(1'b1, {id, code[5]});
        drive(1'b0, {code[4:0], bank, row[10:9]});
        drive(1'b0, {row[8:0], 1'b0});
        drive(1'b0, {3'b000, col});
    endtask

    // Sends one packet and checks outputs in the cycle after word 3 and the one after.
    task automatic run_pkt(input string tag, input logic [8:0] id, input logic [5:0] code,
                           input logic [2:0] bank, input logic [10:0] row,
                           input logic [6:0] col);
        bit exp_hit = ref_match(id, OWN_ID);
        send_words(id, code, bank, row, col);
        drive(1'b0, 10'h000);
        check({tag, " R2/R4/R5/R7 valid"}, cmd_valid, exp_hit);
        if (exp_hit) begin
            check({tag, " R3 code"}, cmd_code, code);
            check({tag, " R3 bank"}, cmd_bank, bank);
            check({tag, " R3 row"},  cmd_row, row);
            check({tag, " R3 col"},  cmd_col, col);
            if (!code[5]) begin
                check({tag, " R8 opts"},
                      {cmd_is_data, cmd_activate, cmd_burst8, cmd_write, cmd_close, cmd_dclk_sel},
                      {1'b1, code[4:0]});
            end else begin
                check({tag, " R9 opts"},
                      {cmd_is_data, cmd_activate, cmd_burst8, cmd_write, cmd_close, cmd_dclk_sel},
                      6'b0);
            end
        end
        drive(1'b0, 10'h000);
        check({tag, " R2 pulse ends"}, cmd_valid, 0);
    endtask

    task automatic t_reset;
        rst = 1; bus_flag = 0; bus_word = 0; dev_id_in = OWN_ID;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", cmd_valid, 0);
        check("R1 err in reset", proto_err, 0);
        rst = 0;
        @(negedge clk);
        check("R1 valid after reset", cmd_valid, 0);
        check("R1 err after reset", proto_err, 0);
    endtask

    task automatic t_unicast;
        run_pkt("uni hit", {1'b0, OWN_ID}, 6'b011010, 3'd5, 11'h5A3, 7'h4C);
        run_pkt("uni miss", {1'b0, 8'hA4}, 6'b000101, 3'd1, 11'h001, 7'h01);
        run_pkt("uni read", {1'b0, OWN_ID}, 6'b000101, 3'd2, 11'h7FF, 7'h7F);
    endtask

    task automatic t_group;
        run_pkt("grp bit0", {1'b1, 8'hA4}, 6'b010000, 3'd3, 11'h2AA, 7'h15);
        run_pkt("grp bits2:0", {1'b1, 8'hA3}, 6'b001111, 3'd0, 11'h155, 7'h2A);
        run_pkt("grp self", {1'b1, 8'hA5}, 6'b000011, 3'd7, 11'h400, 7'h40);
        run_pkt("grp miss hi", {1'b1, 8'hB3}, 6'b000011, 3'd7, 11'h400, 7'h40);
        run_pkt("grp miss low", {1'b1, 8'h24}, 6'b000011, 3'd7, 11'h400, 7'h40);
    endtask

    task automatic t_broadcast;
        run_pkt("R6 bcast", 9'h1FF, 6'b011111, 3'd6, 11'h123, 7'h33);
    endtask

    task automatic t_maint;
        run_pkt("maint", {1'b0, OWN_ID}, 6'b111111, 3'd4, 11'h0F0, 7'h0F);
        run_pkt("maint2", 9'h1FF, 6'b100000, 3'd1, 11'h00F, 7'h70);
    endtask

    task automatic t_abort;
        drive(1'b1, {1'b0, OWN_ID, 1'b0});
        drive(1'b0, 10'h3FF);
        #1 check("R10 no err before flag", proto_err, 0);
        drive(1'b1, {1'b0, OWN_ID, 1'b0});
        #1 check("R10 err on mid flag", proto_err, 1);
        drive(1'b0, {5'b00100, 3'd2, 2'b01});
        #1 check("R10 err one cycle", proto_err, 0);
        drive(1'b0, {9'h0AB, 1'b0});
        check("R10 no valid after 2 words", cmd_valid, 0);
        drive(1'b0, {3'b000, 7'h11});
        drive(1'b0, 10'h000);
        check("R10 restarted packet valid", cmd_valid, 1);
        check("R10 restarted row", cmd_row, {2'b01, 9'h0AB});
        check("R10 restarted col", cmd_col, 7'h11);
        drive(1'b0, 10'h000);
    endtask

    task automatic t_noise;
        for (int i = 0; i < 6; i++) begin
            drive(1'b0, 10'(i * 97 + 3));
            #1 check("R11 no err on idle noise", proto_err, 0);
            check("R11 no valid on idle noise", cmd_valid, 0);
        end
        run_pkt("R11 after noise", {1'b0, OWN_ID}, 6'b001000, 3'd1, 11'h321, 7'h05);
    endtask

    task automatic t_back_to_back;
        send_words({1'b0, OWN_ID}, 6'b000100, 3'd1, 11'h111, 7'h01);
        drive(1'b1, {1'b0, OWN_ID, 1'b0});
        check("R2 b2b first valid", cmd_valid, 1);
        check("R2 b2b first col", cmd_col, 7'h01);
        #1 check("R2 b2b flag after end no err", proto_err, 0);
        drive(1'b0, {5'b00000, 3'd2, 2'b00});
        check("R2 b2b gap", cmd_valid, 0);
        drive(1'b0, {9'h022, 1'b0});
        drive(1'b0, {3'b000, 7'h02});
        drive(1'b0, 10'h000);
        check("R2 b2b second valid", cmd_valid, 1);
        check("R2 b2b second col", cmd_col, 7'h02);
        drive(1'b0, 10'h000);
    endtask

    task automatic t_id_latch;
        dev_id_in = 8'h00;
        run_pkt("R12 old id", {1'b0, OWN_ID}, 6'b000000, 3'd0, 11'h000, 7'h00);
        run_pkt("R12 new id ignored", {1'b0, 8'h00}, 6'b000000, 3'd0, 11'h000, 7'h00);
        dev_id_in = OWN_ID;
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_unicast();
                t_group();
                t_broadcast();
                t_maint();
                t_abort();
                t_noise();
                t_back_to_back();
                t_id_latch();
            end
            begin
                repeat (20000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog actual=expired expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule